// File: doc/BRIEF.md
# Banked event record packer

This block turns a stream of named data banks into complete event records that a host-side acquisition program can parse directly. The producer offers one bank at a time as a plain sequence of 32-bit words under a valid/ready handshake: the packed four-character name, the type code, the payload word count (which also carries the last-bank marker) and then the payload words themselves. The block places every bank, with its own header and alignment filler, in an internal store. Once the last bank has arrived it emits the record: the event header, the global bank header and then the stored banks. Start-of-record and end-of-record markers frame the output stream.

The size fields sit ahead of the data they describe, so a record has to be complete before its first word can leave. The block applies the older accounting rule for bank sizes. Under that rule, each bank is charged its 12-byte header plus its payload rounded up to 8 bytes. The header itself is not rounded. Each record is padded with filler words to a whole 256-bit beat so that it fits a wide host write path. The block also counts records, stamps each one with the value of a free-running cycle counter, and drops any record that is too large for the store, raising a sticky error flag.

Top module: `evpk_top`

## Requirements
- R1: Output word 0 of a record is the ID word: `cfg_event_id` in bits 15:0 and `cfg_trig_mask` in bits 31:16. Both inputs are held stable while the record is input and output.
- R2: Output word 1 is the serial number. It is 0 for the first record after reset and rises by one for each record emitted. Dropped records do not advance it.
- R3: Output word 2 is the time stamp. It is the number of rising clock edges since reset release, counted up to the edge that accepts the first word of the record.
- R4: Output word 3, the event data size, equals 8 plus the all-bank size. It is the record length in bytes, excluding the 16-byte event header and the tail filler.
- R5: Output word 4, the all-bank size, is the sum over banks of 12 + (4·n rounded up to a multiple of 8), where n is the payload word count. Output word 5 is the flags value 0x00000011.
- R6: Each bank appears after the global header, in input order. It consists of three header words (the name word as given, the type word as given, and the payload size in bytes, 4·n unpadded), followed by its n payload words unchanged.
- R7: A bank with an odd payload word count is followed by one filler word of value 0x00000000 before the next bank.
- R8: After the last bank, filler words of value 0 are added until the record length is a multiple of 8 words. `out_sop` marks the first word of a record and `out_eop` marks its last word.
- R9: A record whose banks, headers and bank filler exceed BUF_WORDS words produces no output. It sets `err_ovf`, which stays set until reset. A record of exactly BUF_WORDS body words is emitted normally.
- R10: `in_ready` is low while a record is being output. When `out_valid` is high and `out_ready` is low, the output word and its markers hold unchanged until the next cycle.
- R11: A bank with a payload count of 0 occupies exactly its three header words and adds 12 to the all-bank size.
- R12: In the count word, the payload word count is bits 15:0 of `in_data`. `in_final` is sampled only together with the count word, and it marks that bank as the last one of the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_event_id | input | 16 | Event ID placed in the ID word |
| cfg_trig_mask | input | 16 | Trigger mask placed in the ID word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 32 | Bank name, type, count or payload word |
| in_final | input | 1 | With the count word: this bank closes the record |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts an output word |
| out_data | output | 32 | Record word |
| out_sop | output | 1 | First word of a record |
| out_eop | output | 1 | Last word of a record |
| err_ovf | output | 1 | Sticky flag: a record was dropped for size |

## Verification
The hardest case to reach from the ports is the boundary of the store. A record that fills it to the last word must pass, and a record only two words longer must vanish without touching the serial count. The stimulus reaches this with two large banks whose odd and even payload counts, together with their filler, total exactly BUF_WORDS, and then 258 words. A normal record follows the drop, to show that the serial number and the output continue cleanly. Other records vary the odd and even counts, include an empty bank and a non-default type code, and apply a pattern of sink stalls while the packed words are checked one by one against a model built from the rules above.

// File: rtl/evpk_pkg.sv
package evpk_pkg;

  localparam logic [31:0] FLAGS_WORD = 32'h0000_0011;
  localparam logic [31:0] FILL_WORD  = 32'h0000_0000;
  localparam int          HDR_WORDS  = 6;
  localparam int          BEAT_WORDS = 8;

  typedef enum logic [2:0] {
    IG_NAME, IG_TYPE, IG_CNT, IG_PAY, IG_PAD, IG_HAND, IG_WAIT
  } ig_state_t;

  // legacy accounting: 12-byte header plus payload bytes rounded to 8
  function automatic logic [31:0] bank_acct(input logic [15:0] n);
    logic [31:0] pb;
    pb = {14'd0, n, 2'b00};
    return 32'd12 + ((pb + 32'd7) & ~32'd7);
  endfunction

  // whole record in words, padded to one wide beat
  function automatic logic [31:0] rec_total_words(input logic [31:0] body);
    return (body + HDR_WORDS + BEAT_WORDS - 1) & ~(BEAT_WORDS - 1);
  endfunction

endpackage

// File: rtl/evpk_store.sv
module evpk_store #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/evpk_ingest.sv
module evpk_ingest
  import evpk_pkg::*;
#(
  parameter int BUF_WORDS = 256,
  parameter int AW        = 8,
  parameter int CNT_W     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  input  logic          in_final,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          first_acc,
  output logic          rec_push,
  output logic          rec_drop,
  output logic [AW:0]   rec_words,
  output logic [31:0]   rec_bytes,
  input  logic          emit_done
);
  ig_state_t        st;
  logic [AW:0]      wptr;
  logic [CNT_W-1:0] rem;
  logic             odd_l, fin_l, ovf;
  logic [31:0]      abytes;
  logic             acc, wr_req, full;
  logic [CNT_W-1:0] n_in;

  assign n_in     = in_data[CNT_W-1:0];
  assign in_ready = (st == IG_NAME) || (st == IG_TYPE) || (st == IG_CNT) || (st == IG_PAY);
  assign acc      = in_valid && in_ready;
  assign wr_req   = acc || (st == IG_PAD);
  assign full     = (wptr == (AW+1)'(BUF_WORDS));
  assign wr_en    = wr_req && !full;
  assign wr_addr  = wptr[AW-1:0];

  always_comb begin
    if (st == IG_CNT)      wr_data = {{(30-CNT_W){1'b0}}, n_in, 2'b00};
    else if (st == IG_PAD) wr_data = FILL_WORD;
    else                   wr_data = in_data;
  end

  assign first_acc = acc && (st == IG_NAME) && (wptr == '0);
  assign rec_push  = (st == IG_HAND) && !ovf;
  assign rec_drop  = (st == IG_HAND) && ovf;
  assign rec_words = wptr;
  assign rec_bytes = abytes;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= IG_NAME;
      wptr   <= '0;
      rem    <= '0;
      odd_l  <= 1'b0;
      fin_l  <= 1'b0;
      ovf    <= 1'b0;
      abytes <= '0;
    end else begin
      if (wr_req) begin
        if (full) ovf  <= 1'b1;
        else      wptr <= wptr + 1'b1;
      end
      case (st)
        IG_NAME: if (acc) st <= IG_TYPE;
        IG_TYPE: if (acc) st <= IG_CNT;
        IG_CNT: if (acc) begin
          rem    <= n_in;
          odd_l  <= n_in[0];
          fin_l  <= in_final;
          abytes <= abytes + bank_acct(16'(n_in));
          if (n_in == '0) st <= in_final ? IG_HAND : IG_NAME;
          else            st <= IG_PAY;
        end
        IG_PAY: if (acc) begin
          rem <= rem - 1'b1;
          if (rem == CNT_W'(1)) begin
            if (odd_l)      st <= IG_PAD;
            else if (fin_l) st <= IG_HAND;
            else            st <= IG_NAME;
          end
        end
        IG_PAD: st <= fin_l ? IG_HAND : IG_NAME;
        IG_HAND: begin
          if (ovf) begin
            st     <= IG_NAME;
            wptr   <= '0;
            ovf    <= 1'b0;
            abytes <= '0;
          end else begin
            st <= IG_WAIT;
          end
        end
        IG_WAIT: if (emit_done) begin
          st     <= IG_NAME;
          wptr   <= '0;
          abytes <= '0;
        end
        default: st <= IG_NAME;
      endcase
    end
  end
endmodule

// File: rtl/evpk_emit.sv
module evpk_emit
  import evpk_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW:0]   rec_words,
  input  logic [31:0]   rec_bytes,
  input  logic [31:0]   ts_in,
  input  logic [15:0]   cfg_event_id,
  input  logic [15:0]   cfg_trig_mask,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          emit_done,
  output logic          busy
);
  logic          act;
  logic [IW-1:0] idx, tot, body_end;
  logic [31:0]   ab, tsl, hdr0, serial;
  logic          beat, last;

  assign busy      = act;
  assign out_valid = act;
  assign last      = (idx == tot - 1'b1);
  assign beat      = act && out_ready;
  assign emit_done = beat && last;
  assign out_sop   = act && (idx == '0);
  assign out_eop   = act && last;
  assign rd_addr   = AW'(idx - IW'(HDR_WORDS));

  always_comb begin
    case (idx)
      IW'(0):  out_data = hdr0;
      IW'(1):  out_data = serial;
      IW'(2):  out_data = tsl;
      IW'(3):  out_data = ab + 32'd8;
      IW'(4):  out_data = ab;
      IW'(5):  out_data = FLAGS_WORD;
      default: out_data = (idx < body_end) ? rd_data : FILL_WORD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      idx      <= '0;
      tot      <= '0;
      body_end <= '0;
      ab       <= '0;
      tsl      <= '0;
      hdr0     <= '0;
      serial   <= '0;
    end else if (push && !act) begin
      act      <= 1'b1;
      idx      <= '0;
      tot      <= IW'(rec_total_words(32'(rec_words)));
      body_end <= IW'(HDR_WORDS) + IW'(rec_words);
      ab       <= rec_bytes;
      tsl      <= ts_in;
      hdr0     <= {cfg_trig_mask, cfg_event_id};
    end else if (beat) begin
      if (last) begin
        act    <= 1'b0;
        serial <= serial + 32'd1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evpk_top.sv
module evpk_top
  import evpk_pkg::*;
#(
  parameter int BUF_WORDS = 256,
  parameter int CNT_W     = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cfg_event_id,
  input  logic [15:0] cfg_trig_mask,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_final,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        err_ovf
);
  localparam int AW    = $clog2(BUF_WORDS);
  localparam int IW    = AW + 2;
  localparam int REC_W = AW + 1;

  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic          first_acc, rec_push, rec_drop, emit_done, emit_busy;
  logic [AW:0]   rec_words;
  logic [31:0]   rec_bytes;
  logic [31:0]   timer, ts_hold;

  evpk_ingest #(.BUF_WORDS(BUF_WORDS), .AW(AW), .CNT_W(CNT_W)) u_ingest (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_final(in_final), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .first_acc(first_acc), .rec_push(rec_push),
    .rec_drop(rec_drop), .rec_words(rec_words), .rec_bytes(rec_bytes),
    .emit_done(emit_done)
  );

  evpk_store #(.DEPTH(BUF_WORDS), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  evpk_emit #(.AW(AW), .IW(IW)) u_emit (
    .clk(clk), .rst(rst), .push(rec_push), .rec_words(rec_words),
    .rec_bytes(rec_bytes), .ts_in(ts_hold), .cfg_event_id(cfg_event_id),
    .cfg_trig_mask(cfg_trig_mask), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .emit_done(emit_done),
    .busy(emit_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      timer   <= '0;
      ts_hold <= '0;
      err_ovf <= 1'b0;
    end else begin
      timer <= timer + 32'd1;
      if (first_acc) ts_hold <= timer;
      if (rec_drop)  err_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/evpk_checker.sv
module evpk_checker #(
  parameter int REC_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic             out_sop,
  input logic             out_eop,
  input logic             in_ready,
  input logic             err_ovf,
  input logic             emit_busy,
  input logic             rec_push,
  input logic [REC_W-1:0] rec_words,
  input logic [31:0]      rec_bytes
);
  logic [15:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (rst) beat_cnt <= '0;
    else if (out_valid && out_ready) beat_cnt <= out_eop ? 16'd0 : beat_cnt + 16'd1;
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  // R10
  in_block_chk: assert property (@(posedge clk) disable iff (rst)
    emit_busy |-> !in_ready);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_ovf |=> err_ovf);

  // R5
  acct_match_chk: assert property (@(posedge clk) disable iff (rst)
    rec_push |-> rec_bytes == (32'(rec_words) << 2));

  // R8
  beat_align_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eop |-> beat_cnt[2:0] == 3'd7);

  // R8
  sop_first_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sop |-> beat_cnt == 16'd0);
endmodule

bind evpk_top evpk_checker #(.REC_W(REC_W)) i_evpk_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
  .in_ready(in_ready), .err_ovf(err_ovf), .emit_busy(emit_busy),
  .rec_push(rec_push), .rec_words(rec_words), .rec_bytes(rec_bytes)
);

// File: tb/test_evpk_top.sv
module test_evpk_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cfg_event_id, cfg_trig_mask;
  logic        in_valid, in_ready, in_final;
  logic [31:0] in_data;
  logic        out_valid, out_ready, out_sop, out_eop, err_ovf;
  logic [31:0] out_data;

  evpk_top i_evpk_top (
    .clk(clk), .rst(rst), .cfg_event_id(cfg_event_id), .cfg_trig_mask(cfg_trig_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_final(in_final),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .err_ovf(err_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, exp_serial = 0;
  bit bp_en = 1'b0, finished = 1'b0;
  logic [31:0] qd[$];
  bit          qs[$], qe[$];
  string       qt[$];
  int          bk_n[4];
  logic [31:0] bk_name[4], bk_type[4];

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input int b, input int i);
    return 32'hC0DE_0000 ^ (32'(b) << 12) ^ (32'(i) * 32'h0000_9E37);
  endfunction

  // sink stall pattern and output monitor
  always @(negedge clk) begin
    out_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (!rst && out_valid) begin
      check(!in_ready, "R10 in_ready during output", {31'd0, in_ready}, 32'd0);
      if (out_ready) begin
        if (qd.size() == 0) begin
          check(1'b0, "R9 unexpected output word", out_data, 32'd0);
        end else begin
          logic [31:0] d; bit s, e; string t;
          d = qd.pop_front(); s = qs.pop_front(); e = qe.pop_front(); t = qt.pop_front();
          check(out_data === d, t, out_data, d);
          check(out_sop === s && out_eop === e, "R8 markers",
                {30'd0, out_sop, out_eop}, {30'd0, s, e});
        end
      end
    end
  end

  task automatic send_word(input logic [31:0] d, input bit f, output int acc_cyc);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_final = f;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    acc_cyc = cyc;
    @(posedge clk);
  endtask

  task automatic push_exp(input logic [31:0] d, input string t);
    qd.push_back(d); qs.push_back(1'b0); qe.push_back(1'b0); qt.push_back(t);
  endtask

  task automatic run_record(input int nb, input bit drop);
    int ts, c, ab;
    logic [31:0] body[$];
    string btag[$];
    ab = 0;
    for (int b = 0; b < nb; b++) begin
      send_word(bk_name[b], 1'b0, c);
      if (b == 0) ts = c;
      send_word(bk_type[b], 1'b0, c);
      send_word(32'hFFFF_0000 | 32'(bk_n[b]), b == nb - 1, c); // R12: upper bits ignored
      for (int i = 0; i < bk_n[b]; i++) send_word(pay(b, i), 1'b0, c);
      body.push_back(bk_name[b]);    btag.push_back(bk_n[b] == 0 ? "R11 name" : "R6 name");
      body.push_back(bk_type[b]);    btag.push_back(bk_n[b] == 0 ? "R11 type" : "R6 type");
      body.push_back(32'(bk_n[b] * 4)); btag.push_back(bk_n[b] == 0 ? "R11 size" : "R6 size");
      for (int i = 0; i < bk_n[b]; i++) begin
        body.push_back(pay(b, i)); btag.push_back("R6 payload");
      end
      if (bk_n[b] % 2 == 1) begin
        body.push_back(32'd0); btag.push_back("R7 bank filler");
      end
      ab += 12 + ((bk_n[b] * 4 + 7) / 8) * 8;
    end
    @(negedge clk);
    in_valid = 1'b0; in_final = 1'b0;
    if (!drop) begin
      int total;
      push_exp({cfg_trig_mask, cfg_event_id}, "R1 id word");
      qs[qs.size()-1] = 1'b1;
      push_exp(32'(exp_serial), "R2 serial");
      push_exp(32'(ts), "R3 time stamp");
      push_exp(32'(ab + 8), "R4 event size");
      push_exp(32'(ab), "R5 all-bank size");
      push_exp(32'h11, "R5 flags");
      foreach (body[k]) push_exp(body[k], btag[k]);
      total = 6 + body.size();
      while (total % 8 != 0) begin
        push_exp(32'd0, "R8 tail filler");
        total++;
      end
      qe[qe.size()-1] = 1'b1;
      exp_serial++;
    end
  endtask

  task automatic drain();
    int lim = 0;
    while (qd.size() != 0 && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
    repeat (4) @(negedge clk);
    check(qd.size() == 0, "R8 record fully emitted", 32'(qd.size()), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_final = 1'b0; out_ready = 1'b1;
    cfg_event_id = 16'h0001; cfg_trig_mask = 16'h0001;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(out_valid === 1'b0, "R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    check(err_ovf === 1'b0, "R9 reset err_ovf", {31'd0, err_ovf}, 32'd0);
    check(in_ready === 1'b1, "R10 reset in_ready", {31'd0, in_ready}, 32'd1);

    // one odd bank
    bk_name[0] = 32'h4645_4230; bk_type[0] = 32'd6; bk_n[0] = 3;
    run_record(1, 1'b0); drain();

    // even bank then an empty bank (R11), new id
    cfg_event_id = 16'h1234; cfg_trig_mask = 16'hA5A5;
    bk_name[0] = 32'h4141_4141; bk_type[0] = 32'd6; bk_n[0] = 2;
    bk_name[1] = 32'h4242_4242; bk_type[1] = 32'd6; bk_n[1] = 0;
    run_record(2, 1'b0); drain();

    // sink stalls, other type code (R10, R6)
    bp_en = 1'b1;
    cfg_event_id = 16'hBEEF; cfg_trig_mask = 16'h0F0F;
    bk_name[0] = 32'h5858_3031; bk_type[0] = 32'd4; bk_n[0] = 5;
    bk_name[1] = 32'h5858_3032; bk_type[1] = 32'd6; bk_n[1] = 1;
    bk_name[2] = 32'h5858_3033; bk_type[2] = 32'd6; bk_n[2] = 4;
    run_record(3, 1'b0); drain();
    bp_en = 1'b0;

    // exact fit: body 3+126+3+124 = 256 words (R9)
    bk_name[0] = 32'h4249_4731; bk_type[0] = 32'd6; bk_n[0] = 125;
    bk_name[1] = 32'h4249_4732; bk_type[1] = 32'd6; bk_n[1] = 124;
    run_record(2, 1'b0); drain();
    check(err_ovf === 1'b0, "R9 exact fit no error", {31'd0, err_ovf}, 32'd0);

    // overflow: body 258 words, dropped (R9)
    bk_n[1] = 125;
    run_record(2, 1'b1);
    repeat (6) @(negedge clk);
    #1;
    check(err_ovf === 1'b1, "R9 drop sets error", {31'd0, err_ovf}, 32'd1);
    check(out_valid === 1'b0, "R9 drop no output", {31'd0, out_valid}, 32'd0);

    // normal record after a drop: serial continues (R2)
    cfg_event_id = 16'h0042; cfg_trig_mask = 16'h8001;
    bk_name[0] = 32'h4146_5452; bk_type[0] = 32'd6; bk_n[0] = 4;
    run_record(1, 1'b0); drain();
    check(err_ovf === 1'b1, "R9 error sticky", {31'd0, err_ovf}, 32'd1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule